// File: doc/BRIEF.md
# Crystal Oscillator Interrupt Enable Register

This block holds the interrupt enables for a 32.768 kHz crystal oscillator controller and turns the controller's two hardware event flags into one interrupt request. Software sees the same enable state at two byte offsets on a small register bus. One offset turns enables on and the other turns them off. In both, only the bits written as 1 act. Software can therefore change one enable without reading the register first.

Two enables exist: one for the oscillator-ready event and one for the clock-failure event. A write-protect input locks the register. While it is high, every bus write is dropped and the block answers with a one-cycle error pulse. The request output is registered. It is high when an enabled event flag is set. A test input makes one write strobe act on both views at once, and a clear then overrides a set to the same bit.

Top module: `osc_irq_enable`

## Requirements
- R1: After synchronous reset both enables are 0, both views read 0x00000000, and `irq_req` and `lock_err` are 0.
- R2: A write to offset 0x04 with bit 0 (ready) or bit 2 (failure) at 1 sets that enable. The new value reads back from both 0x00 and 0x04 in the cycle after the write edge.
- R3: A write to offset 0x00 with bit 0 or bit 2 at 1 clears that enable. The result is seen in both views after the write edge.
- R4: A 0 in any bit of a write to either view leaves the matching enable unchanged.
- R5: Bit 1 and bits 31..3 are not stored and always read 0 from both views, whatever was written to them.
- R6: A read from any offset other than 0x00 or 0x04 returns 0. A write to such an offset changes no enable.
- R7: A write while `wr_lock` is high changes no enable. `lock_err` is high for exactly the one cycle after each locked write edge and is low otherwise.
- R8: `irq_req` is a register that, one edge after its inputs, takes the OR of (`flag_ready` AND ready enable) and (`flag_fail` AND failure enable).
- R9: With `dual_strobe` high, an unlocked write acts as a set and a clear with the same data, whatever the address. For a bit written as 1 the clear wins and the enable ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dual_strobe | input | 1 | Test mode: one write acts on both views |
| wr_lock | input | 1 | Write protection; drops writes when high |
| flag_ready | input | 1 | Oscillator-ready event flag |
| flag_fail | input | 1 | Clock-failure event flag |
| lock_err | output | 1 | One-cycle pulse after a dropped write |
| irq_req | output | 1 | Registered interrupt request |

## Verification
A write takes effect at the clock edge that samples the strobe. Read data is combinational, so the bench checks readback and `lock_err` at the falling edge right after that write edge. `irq_req` comes one register further down. Flag changes are checked one edge after they are applied. Enable changes are checked two edges after the write: one edge for the enable flop and one for the request flop. The bench also checks at the first falling edge, before the request flop has reloaded, that `irq_req` still shows the old value. The bench sweeps every 4-bit write pattern through both views and all flag and enable pairs against a software model of the enables.

// File: rtl/osc_irq_pkg.sv
package osc_irq_pkg;

    localparam int EN_W      = 3;
    localparam int BIT_READY = 0;
    localparam int BIT_FAIL  = 2;
    localparam logic [EN_W-1:0] IMPL_MASK = (EN_W'(1) << BIT_READY) | (EN_W'(1) << BIT_FAIL);

    typedef logic [EN_W-1:0] en_vec_t;

    typedef enum logic [1:0] {
        VIEW_NONE = 2'd0,
        VIEW_CLR  = 2'd1,
        VIEW_SET  = 2'd2
    } view_e;

    typedef struct packed {
        en_vec_t set_m;
        en_vec_t clr_m;
    } wr_cmd_t;

    function automatic en_vec_t keep_impl(input en_vec_t raw);
        return raw & IMPL_MASK;
    endfunction

    function automatic en_vec_t apply_cmd(input en_vec_t cur, input wr_cmd_t c);
        return keep_impl((cur | c.set_m) & ~c.clr_m);
    endfunction

endpackage

// File: rtl/osc_irq_decode.sv
module osc_irq_decode
    import osc_irq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CLR_OFF = 0,
    parameter int SET_OFF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              dual_strobe,
    input  logic              wr_lock,
    output wr_cmd_t           cmd,
    output view_e             view,
    output logic              lock_err
);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFF);
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFF);

    logic    wr_ok;
    en_vec_t data_bits;

    always_comb begin
        if (bus_addr == CLR_A)      view = VIEW_CLR;
        else if (bus_addr == SET_A) view = VIEW_SET;
        else                        view = VIEW_NONE;
    end

    assign wr_ok     = bus_we && !wr_lock;
    assign data_bits = keep_impl(bus_wdata[EN_W-1:0]);

    always_comb begin
        cmd = '0;
        if (wr_ok) begin
            if (dual_strobe) begin
                cmd.set_m = data_bits;
                cmd.clr_m = data_bits;
            end else if (view == VIEW_SET) begin
                cmd.set_m = data_bits;
            end else if (view == VIEW_CLR) begin
                cmd.clr_m = data_bits;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lock_err <= 1'b0;
        else     lock_err <= bus_we && wr_lock;
    end

    a_r7_locked_no_cmd: assert property (@(posedge clk) disable iff (rst)
        wr_lock |-> (cmd.set_m == '0 && cmd.clr_m == '0));
    a_r7_err_after_lock: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wr_lock) |=> lock_err);
    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && wr_lock) |=> !lock_err);

endmodule

// File: rtl/osc_irq_store.sv
module osc_irq_store
    import osc_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    output en_vec_t en
);
    always_ff @(posedge clk) begin
        if (rst) en <= '0;
        else     en <= apply_cmd(en, cmd);
    end

    for (genvar b = 0; b < EN_W; b++) begin : g_chk
        if (IMPL_MASK[b]) begin : g_impl
            a_r2_set_bit: assert property (@(posedge clk) disable iff (rst)
                (cmd.set_m[b] && !cmd.clr_m[b]) |=> en[b]);
            a_r3_clr_bit: assert property (@(posedge clk) disable iff (rst)
                cmd.clr_m[b] |=> !en[b]);
            a_r4_hold_bit: assert property (@(posedge clk) disable iff (rst)
                (!cmd.set_m[b] && !cmd.clr_m[b]) |=> $stable(en[b]));
        end else begin : g_unimpl
            a_r5_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
                cmd.set_m[b] |=> !en[b]);
        end
    end

endmodule

// File: rtl/osc_irq_req.sv
module osc_irq_req
    import osc_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  en_vec_t en,
    input  en_vec_t flags,
    output logic    irq
);
    en_vec_t hits;
    assign hits = keep_impl(en & flags);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |hits;
    end

endmodule

// File: rtl/osc_irq_enable.sv
module osc_irq_enable
    import osc_irq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CLR_OFF = 0,
    parameter int SET_OFF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dual_strobe,
    input  logic              wr_lock,
    input  logic              flag_ready,
    input  logic              flag_fail,
    output logic              lock_err,
    output logic              irq_req
);
    wr_cmd_t cmd;
    view_e   view;
    en_vec_t en;
    en_vec_t flags;

    osc_irq_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CLR_OFF(CLR_OFF),
        .SET_OFF(SET_OFF)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .dual_strobe(dual_strobe),
        .wr_lock    (wr_lock),
        .cmd        (cmd),
        .view       (view),
        .lock_err   (lock_err)
    );

    osc_irq_store u_store (
        .clk(clk),
        .rst(rst),
        .cmd(cmd),
        .en (en)
    );

    always_comb begin
        flags            = '0;
        flags[BIT_READY] = flag_ready;
        flags[BIT_FAIL]  = flag_fail;
    end

    osc_irq_req u_req (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .flags(flags),
        .irq  (irq_req)
    );

    always_comb begin
        bus_rdata = '0;
        if (view != VIEW_NONE) bus_rdata[EN_W-1:0] = en;
    end

    a_r5_rdata_upper: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[DATA_W-1:EN_W] == '0) && !bus_rdata[1]);
    a_r7_lock_keeps_en: assert property (@(posedge clk) disable iff (rst)
        (bus_we && wr_lock) |=> $stable(en));
    a_r8_no_enable_no_irq: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |=> !irq_req);
    a_r8_ready_raises: assert property (@(posedge clk) disable iff (rst)
        (flag_ready && en[BIT_READY]) |=> irq_req);
    a_r8_fail_raises: assert property (@(posedge clk) disable iff (rst)
        (flag_fail && en[BIT_FAIL]) |=> irq_req);
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !wr_lock && dual_strobe && bus_wdata[BIT_READY]) |=> !en[BIT_READY]);

endmodule

// File: tb/osc_irq_enable_tb.sv
module osc_irq_enable_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        dual_strobe;
    logic        wr_lock;
    logic        flag_ready;
    logic        flag_fail;
    logic        lock_err;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    logic [2:0] model;

    always #4 clk = ~clk;

    osc_irq_enable u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dual_strobe(dual_strobe),
        .wr_lock(wr_lock), .flag_ready(flag_ready), .flag_fail(flag_fail),
        .lock_err(lock_err), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] view_val();
        return {29'd0, model[2], 1'b0, model[0]};
    endfunction

    task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    function automatic logic want_irq();
        return (flag_ready & model[0]) | (flag_fail & model[2]);
    endfunction

    // Drives at a falling edge, returns at the next falling edge (one write edge later).
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic dual, input logic lk);
        logic [2:0] bits;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; dual_strobe = dual; wr_lock = lk;
        @(negedge clk);
        bus_we = 1'b0; dual_strobe = 1'b0; wr_lock = 1'b0;
        bits = {d[2], 1'b0, d[0]};
        if (!lk) begin
            if (dual)          model = model & ~bits;
            else if (a == 4'h4) model = model | bits;
            else if (a == 4'h0) model = model & ~bits;
        end
        chk(lk ? "R7 lock_err pulse" : "R7 lock_err idle", {31'd0, lock_err}, {31'd0, lk});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        dual_strobe = 1'b0; wr_lock = 1'b0; flag_ready = 1'b1; flag_fail = 1'b1;
        model = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        read_chk("R1 clr view", 4'h0, 32'h0);
        read_chk("R1 set view", 4'h4, 32'h0);
        chk("R1 irq", {31'd0, irq_req}, 32'h0);
        chk("R1 lock_err", {31'd0, lock_err}, 32'h0);

        // R2 R3 R4 R5: sweep all low nibbles with high junk through both views
        for (int p = 0; p < 16; p++) begin
            wr(4'h4, 32'hFFFF_FFF0 | 32'(p), 1'b0, 1'b0);
            read_chk("R2 set seen in clr view", 4'h0, view_val());
            read_chk("R5 set view unimpl zero", 4'h4, view_val());
            for (int q = 0; q < 16; q++) begin
                wr(4'h4, 32'(p), 1'b0, 1'b0);
                wr(4'h0, 32'hA5A5_A5A0 | 32'(q), 1'b0, 1'b0);
                read_chk("R3 clear seen in set view", 4'h4, view_val());
                read_chk("R4 zero bits hold", 4'h0, view_val());
            end
        end

        // R6 other offsets
        wr(4'h4, 32'h5, 1'b0, 1'b0);
        for (int a = 0; a < 16; a++) begin
            if (a != 0 && a != 4) begin
                wr(4'(a), 32'hFFFF_FFFF, 1'b0, 1'b0);
                read_chk("R6 write elsewhere ignored", 4'h0, 32'h5);
                read_chk("R6 read elsewhere zero", 4'(a), 32'h0);
            end
        end

        // R7 locked writes
        wr(4'h0, 32'h5, 1'b0, 1'b1);
        read_chk("R7 locked clear ignored", 4'h0, 32'h5);
        @(negedge clk);
        chk("R7 lock_err one cycle", {31'd0, lock_err}, 32'h0);
        wr(4'h0, 32'h5, 1'b0, 1'b0);
        wr(4'h4, 32'h5, 1'b0, 1'b1);
        read_chk("R7 locked set ignored", 4'h4, 32'h0);

        // R8 flag x enable sweep
        for (int e = 0; e < 4; e++) begin
            for (int f = 0; f < 4; f++) begin
                wr(4'h0, 32'h5, 1'b0, 1'b0);
                wr(4'h4, {29'd0, e[1], 1'b0, e[0]}, 1'b0, 1'b0);
                flag_ready = f[0]; flag_fail = f[1];
                @(negedge clk);
                chk("R8 irq after one edge", {31'd0, irq_req}, {31'd0, want_irq()});
            end
        end
        // R8 enable-to-irq latency: old value at first falling edge, new one after second
        wr(4'h0, 32'h5, 1'b0, 1'b0);
        flag_ready = 1'b1; flag_fail = 1'b0;
        @(negedge clk);
        chk("R8 irq low before enable", {31'd0, irq_req}, 32'h0);
        wr(4'h4, 32'h1, 1'b0, 1'b0);
        chk("R8 irq not yet updated", {31'd0, irq_req}, 32'h0);
        @(negedge clk);
        chk("R8 irq after enable", {31'd0, irq_req}, 32'h1);

        // R9 dual strobe clear wins, at either address
        wr(4'h4, 32'h5, 1'b0, 1'b0);
        wr(4'h4, 32'h1, 1'b1, 1'b0);
        read_chk("R9 clear wins bit0", 4'h0, 32'h4);
        wr(4'h0, 32'h4, 1'b1, 1'b0);
        read_chk("R9 clear wins bit2", 4'h4, 32'h0);
        wr(4'h4, 32'h5, 1'b0, 1'b0);
        wr(4'h8, 32'h5, 1'b1, 1'b0);
        read_chk("R9 any address", 4'h0, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule